// File: doc/BRIEF.md
# Sequential Integer Quotient Unit

This block computes the 32-bit quotient of two operands over several clock cycles, producing one quotient bit per cycle with a radix-2 restoring shift-subtract loop. A single select input chooses between two's-complement and unsigned interpretation of both operands. Only the quotient comes out; the remainder is discarded inside the engine.

A result is never refused and no exception is raised. A zero divisor is swapped for a divisor of one before the loop starts. In signed mode the one case whose true quotient does not fit, the most negative value divided by minus one, gets the same swap. In both cases the quotient then equals the dividend. Each operation carries a 5-bit destination register index through the pipeline. When that index is zero the quotient is still computed and presented, but the write strobe stays low, so a register-file writer can use `wr_en` directly.

The caller raises `start` while `busy` is low. One accepted operation occupies the block until its `done` pulse. Requests that arrive while it is occupied are dropped.

Top module: `idiv_seq`

## Requirements
- R1: With `is_signed` low and a nonzero divisor, `quotient` equals the unsigned floor of dividend divided by divisor.
- R2: With `is_signed` low and a divisor of zero, `quotient` equals the dividend.
- R3: With `is_signed` high and no guarded case, `quotient` is the two's-complement quotient truncated toward zero. It is negative exactly when the operand signs differ and the magnitude quotient is nonzero.
- R4: With `is_signed` high and a divisor of zero, `quotient` equals the dividend.
- R5: With `is_signed` high, a dividend of 0x80000000 and a divisor of 0xFFFFFFFF, `quotient` is 0x80000000.
- R6: A start is accepted on a rising edge where `start` is high and `busy` is low. `busy` is high from the following cycle until the `done` edge. `done` is high for exactly one cycle, and it rises on the 33rd rising edge after the accepting edge.
- R7: `start` is ignored while `busy` is high. Operands presented then do not change the result or the timing of the operation in flight.
- R8: At `done`, `dest_out` equals the index captured at acceptance. `wr_en` is high in that same cycle exactly when this index is nonzero, and it is low in every other cycle.
- R9: After reset, `busy`, `done` and `wr_en` are low and `quotient` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a new division (honoured only when idle) |
| dividend | input | 32 | Numerator operand |
| divisor | input | 32 | Denominator operand |
| is_signed | input | 1 | 1: two's-complement operands, 0: unsigned |
| dest_idx | input | 5 | Destination register index carried with the operation |
| busy | output | 1 | An operation is in flight |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 32 | Quotient of the most recent completed operation |
| dest_out | output | 5 | Destination index of the most recent completed operation |
| wr_en | output | 1 | Write strobe, high with `done` when `dest_out` is nonzero |

## Verification
Any corruption of the partial remainder or the divisor copy shows up as a wrong `quotient` at the `done` pulse. That is at most 33 cycles after the operation was accepted, so the quotient is compared in that cycle against a behavioural model for every operation. A wrong iteration count or a stuck state moves `done` or the fall of `busy` away from the 33rd edge, and the per-cycle comparison of `busy` and `done` catches it on the first cycle that differs. A lost destination tag or a wrong sign flag appears at that same `done` as a mismatch on `dest_out`, on `wr_en`, or in the sign of `quotient`.

// File: rtl/idiv_pkg.sv
package idiv_pkg;
   typedef enum logic [1:0] {
      IDV_IDLE = 2'd0,
      IDV_RUN  = 2'd1,
      IDV_FIN  = 2'd2
   } idv_state_e;
endpackage

// File: rtl/idiv_prep.sv
module idiv_prep #(
   parameter int W         = 32,
   parameter bit SIGNED_EN = 1'b1
) (
   input  logic [W-1:0] num_i,
   input  logic [W-1:0] den_i,
   input  logic         sgn_i,
   output logic [W-1:0] num_mag_o,
   output logic [W-1:0] den_mag_o,
   output logic         neg_o
);
   localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
   localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

   generate
      if (SIGNED_EN) begin : g_signed
         logic num_neg, den_neg, ovf, den_bad;
         always_comb begin
            num_neg   = sgn_i & num_i[W-1];
            den_neg   = sgn_i & den_i[W-1];
            ovf       = sgn_i && (num_i == MOST_NEG) && (den_i == '1);
            den_bad   = (den_i == '0) || ovf;
            num_mag_o = num_neg ? (~num_i + ONE) : num_i;
            den_mag_o = den_bad ? ONE : (den_neg ? (~den_i + ONE) : den_i);
            neg_o     = den_bad ? num_neg : (num_neg ^ den_neg);
         end
      end else begin : g_unsigned
         logic unused_sgn;
         always_comb begin
            unused_sgn = sgn_i;
            num_mag_o  = num_i;
            den_mag_o  = (den_i == '0) ? ONE : den_i;
            neg_o      = 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/idiv_ctrl.sv
module idiv_ctrl
   import idiv_pkg::*;
#(
   parameter int W = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic load_o,
   output logic step_o,
   output logic fin_o,
   output logic busy_o
);
   localparam int CW = $clog2(W + 1);

   idv_state_e     state_q;
   logic [CW-1:0]  cnt_q;

   always_comb begin
      load_o = start_i && (state_q == IDV_IDLE);
      step_o = (state_q == IDV_RUN);
      fin_o  = (state_q == IDV_FIN);
      busy_o = (state_q != IDV_IDLE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= IDV_IDLE;
         cnt_q   <= '0;
      end else begin
         unique case (state_q)
            IDV_IDLE: if (start_i) begin
               state_q <= IDV_RUN;
               cnt_q   <= CW'(W);
            end
            IDV_RUN: begin
               cnt_q <= cnt_q - 1'b1;
               if (cnt_q == CW'(1)) state_q <= IDV_FIN;
            end
            IDV_FIN: state_q <= IDV_IDLE;
            default: state_q <= IDV_IDLE;
         endcase
      end
   end

   // R6
   fin_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fin_o |=> !fin_o);
   // R7
   no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !load_o);
endmodule

// File: rtl/idiv_engine.sv
module idiv_engine #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic         step_i,
   input  logic [W-1:0] num_i,
   input  logic [W-1:0] den_i,
   output logic [W-1:0] quo_o
);
   logic [W:0]   rem_q;
   logic [W-1:0] den_q;
   logic [W-1:0] quo_q;
   logic [W:0]   rem_sh;
   logic [W:0]   diff;

   always_comb begin
      rem_sh = {rem_q[W-1:0], quo_q[W-1]};
      diff   = rem_sh - {1'b0, den_q};
      quo_o  = quo_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
         den_q <= '0;
         quo_q <= '0;
      end else if (load_i) begin
         rem_q <= '0;
         den_q <= den_i;
         quo_q <= num_i;
      end else if (step_i) begin
         if (!diff[W]) begin
            rem_q <= diff;
            quo_q <= {quo_q[W-2:0], 1'b1};
         end else begin
            rem_q <= rem_sh;
            quo_q <= {quo_q[W-2:0], 1'b0};
         end
      end
   end

   // R1
   rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step_i |=> (rem_q < {1'b0, den_q}));
endmodule

// File: rtl/idiv_post.sv
module idiv_post #(
   parameter int W     = 32,
   parameter int TAG_W = 5
) (
   input  logic [W-1:0]     quo_i,
   input  logic             neg_i,
   input  logic [TAG_W-1:0] tag_i,
   output logic [W-1:0]     res_o,
   output logic             wr_o
);
   always_comb begin
      res_o = neg_i ? (~quo_i + {{(W-1){1'b0}}, 1'b1}) : quo_i;
      wr_o  = (tag_i != '0);
   end
endmodule

// File: rtl/idiv_seq.sv
module idiv_seq #(
   parameter int W         = 32,
   parameter int TAG_W     = 5,
   parameter bit SIGNED_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [W-1:0]     dividend,
   input  logic [W-1:0]     divisor,
   input  logic             is_signed,
   input  logic [TAG_W-1:0] dest_idx,
   output logic             busy,
   output logic             done,
   output logic [W-1:0]     quotient,
   output logic [TAG_W-1:0] dest_out,
   output logic             wr_en
);
   generate
      if (W < 2) begin : g_bad_w
         $error("idiv_seq: W must be at least 2");
      end
      if (TAG_W < 1) begin : g_bad_tag
         $error("idiv_seq: TAG_W must be at least 1");
      end
   endgenerate

   logic             load, step, fin;
   logic [W-1:0]     num_mag, den_mag, quo_raw, res;
   logic             neg, wr_next;
   logic             neg_q;
   logic [TAG_W-1:0] tag_q;

   idiv_prep #(.W(W), .SIGNED_EN(SIGNED_EN)) u_prep (
      .num_i(dividend), .den_i(divisor), .sgn_i(is_signed),
      .num_mag_o(num_mag), .den_mag_o(den_mag), .neg_o(neg));

   idiv_ctrl #(.W(W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start_i(start),
      .load_o(load), .step_o(step), .fin_o(fin), .busy_o(busy));

   idiv_engine #(.W(W)) u_eng (
      .clk(clk), .rst_n(rst_n), .load_i(load), .step_i(step),
      .num_i(num_mag), .den_i(den_mag), .quo_o(quo_raw));

   idiv_post #(.W(W), .TAG_W(TAG_W)) u_post (
      .quo_i(quo_raw), .neg_i(neg_q), .tag_i(tag_q),
      .res_o(res), .wr_o(wr_next));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         neg_q    <= 1'b0;
         tag_q    <= '0;
         quotient <= '0;
         dest_out <= '0;
         done     <= 1'b0;
         wr_en    <= 1'b0;
      end else begin
         if (load) begin
            neg_q <= neg;
            tag_q <= dest_idx;
         end
         done  <= fin;
         wr_en <= fin & wr_next;
         if (fin) begin
            quotient <= res;
            dest_out <= tag_q;
         end
      end
   end

   // R2
   guard_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (den_mag != '0));
   // R6
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R6
   busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);
   // R8
   wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (done && dest_out != '0));
   // R8
   wr_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && dest_out != '0) |-> wr_en);
endmodule

// File: tb/tb_idiv_seq.sv
module tb_idiv_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] dividend = '0, divisor = '0;
   logic        is_signed = 1'b0;
   logic [4:0]  dest_idx = '0;
   logic        busy, done, wr_en;
   logic [31:0] quotient;
   logic [4:0]  dest_out;

   int checks = 0, errors = 0, cyc = 0;
   int cd = 0;
   logic        exp_done = 1'b0;
   logic [31:0] e_q = '0;
   logic [4:0]  e_dst = '0;
   string       e_tag = "R1";
   logic        e_jam = 1'b0, cur_jam = 1'b0;

   always #4 clk = ~clk;

   idiv_seq dut (
      .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
      .divisor(divisor), .is_signed(is_signed), .dest_idx(dest_idx),
      .busy(busy), .done(done), .quotient(quotient), .dest_out(dest_out),
      .wr_en(wr_en));

   function automatic logic [31:0] ref_q(logic [31:0] a, logic [31:0] b, logic s);
      longint sa, sb;
      if (!s) return (b == 0) ? a : a / b;
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      if (sb == 0 || (a == 32'h8000_0000 && b == 32'hFFFF_FFFF)) sb = 1;
      return 32'(sa / sb);
   endfunction

   function automatic string ref_tag(logic [31:0] a, logic [31:0] b, logic s);
      if (!s) return (b == 0) ? "R2" : "R1";
      if (b == 0) return "R4";
      if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return "R5";
      return "R3";
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
      end
   endtask

   // reference model: acceptance and completion timing
   always @(posedge clk) begin
      exp_done = 1'b0;
      if (!rst_n) cd = 0;
      else if (cd > 0) begin
         cd--;
         if (cd == 0) exp_done = 1'b1;
      end else if (start) begin
         cd    = 33;
         e_q   = ref_q(dividend, divisor, is_signed);
         e_tag = ref_tag(dividend, divisor, is_signed);
         e_dst = dest_idx;
         e_jam = cur_jam;
      end
   end

   // per-cycle comparison
   always @(negedge clk) begin
      if (rst_n) begin
         chk(busy == (cd > 0), "R6 busy", 32'(busy), 32'(cd > 0));
         chk(done == exp_done, "R6 done", 32'(done), 32'(exp_done));
         chk(wr_en == (exp_done && e_dst != 0), "R8 wr_en", 32'(wr_en),
             32'(exp_done && e_dst != 0));
         if (exp_done) begin
            chk(quotient == e_q, e_jam ? {e_tag, "/R7 quotient"} : {e_tag, " quotient"},
                quotient, e_q);
            chk(dest_out == e_dst, "R8 dest_out", 32'(dest_out), 32'(e_dst));
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic do_op(input logic [31:0] a, input logic [31:0] b, input logic s,
                        input logic [4:0] d, input bit jam);
      @(negedge clk);
      while (busy) @(negedge clk);
      dividend = a; divisor = b; is_signed = s; dest_idx = d;
      cur_jam = jam; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (jam) begin
         repeat (3) @(negedge clk);
         start = 1'b1; dividend = $urandom; divisor = 32'd0;
         is_signed = ~s; dest_idx = ~d;
         repeat (4) @(negedge clk);
         start = 1'b0;
      end
      while (busy) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R9 reset state
      chk(busy == 0, "R9 busy", 32'(busy), 0);
      chk(done == 0, "R9 done", 32'(done), 0);
      chk(wr_en == 0, "R9 wr_en", 32'(wr_en), 0);
      chk(quotient == 0, "R9 quotient", quotient, 0);
      rst_n = 1'b1;
      // R1
      do_op(32'd100, 32'd7, 0, 5'd3, 0);
      do_op(32'hFFFF_FFFF, 32'd1, 0, 5'd1, 0);
      do_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 5'd31, 0);
      do_op(32'd5, 32'd9, 0, 5'd2, 0);
      // R2
      do_op(32'd5, 32'd0, 0, 5'd4, 0);
      do_op(32'd0, 32'd0, 0, 5'd4, 0);
      // R3
      do_op(-32'sd7, 32'd2, 1, 5'd6, 0);
      do_op(32'd7, -32'sd2, 1, 5'd7, 0);
      do_op(-32'sd7, -32'sd2, 1, 5'd8, 0);
      do_op(32'h8000_0000, 32'h8000_0000, 1, 5'd9, 0);
      do_op(32'h8000_0000, 32'd1, 1, 5'd9, 0);
      do_op(32'd1, -32'sd3, 1, 5'd9, 0);
      // R4
      do_op(-32'sd5, 32'd0, 1, 5'd10, 0);
      // R5
      do_op(32'h8000_0000, 32'hFFFF_FFFF, 1, 5'd11, 0);
      // R8 destination zero suppresses the write
      do_op(32'd81, 32'd9, 0, 5'd0, 0);
      do_op(32'h8000_0000, 32'hFFFF_FFFF, 1, 5'd0, 0);
      // R7 requests while busy are dropped
      do_op(32'd1000, 32'd10, 0, 5'd12, 1);
      do_op(-32'sd1000, 32'd10, 1, 5'd0, 1);
      for (int i = 0; i < 80; i++) begin
         logic [31:0] a, b;
         a = $urandom;
         b = (i % 4 == 0) ? ($urandom & 32'hFF) : $urandom;
         if (i % 9 == 0) b = 32'd0;
         do_op(a, b, i[0], 5'($urandom), (i % 5 == 0));
      end
      repeat (3) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule